// File: doc/BRIEF.md
# Two-Queue Preemptive Conversion Sequencer

This block decides which conversion command word (CCW) a shared analog-to-digital converter runs next. The commands come from two queues that share one table of command entries. Each queue is a window in that table, set by a first index and a last index. The queue at index 0 (the urgent queue) always wins over the queue at index 1 (the background queue). If the urgent queue is triggered while a background command is converting, that conversion is cut off with an abort strobe and the urgent queue runs at once. Once the urgent queue is idle again, the background queue carries on. It resumes either at the first entry of the sub-block it was in or at the entry that was cut off, as a select input chooses.

The sequencer drives a table index and a one-cycle start strobe to the converter, then waits for a one-cycle done strobe. The table returns one flag bit for the index on display. A set flag ends a sub-block, so the sub-block that follows begins at the next index. Each queue runs either once per trigger or over and over. Disabling a queue, changing its mode, or raising the stop request each cut off the conversion that queue owns. A freeze request, when freezing is enabled, only keeps new conversions from starting. Each queue has a sticky completion flag and an interrupt line that is gated by an enable.

Top module: `qseq_top`

## Requirements
- R1: While and right after a synchronous reset, conv_start, conv_abort, ccw_idx, both done flags and both interrupt lines are 0.
- R2: In once-per-trigger mode (mode input 0), a trigger on an enabled idle queue runs entries first..last in increasing order. Each entry gets one conv_start, and the next entry starts only after conv_done. A trigger that arrives while the queue is active is ignored.
- R3: A done flag goes to 1 when the queue's last entry completes and stays at 1 until a one-cycle pulse on the clear bit (bit 0 for the urgent queue, bit 1 for the background queue). The interrupt line equals the done flag AND that queue's interrupt enable.
- R4: An urgent-queue trigger during a background conversion gives a conv_abort pulse, and the urgent entries start next. No done is expected for the aborted entry.
- R5: With resume_at_abort=0, the background queue restarts at the start of its current sub-block. A sub-block starts at the queue's first entry or at the index after a completed entry whose ccw_sub_end was 1 (ccw_sub_end refers to the entry at ccw_idx).
- R6: With resume_at_abort=1, the background queue restarts at the entry that was aborted.
- R7: Taking a queue's enable to 0 while it is converting aborts that conversion, and none of its entries start afterwards. Its done flag stays 0.
- R8: Changing an active queue's mode bit aborts its conversion. The queue then stays idle until the next trigger, which starts it at its first entry.
- R9: stop_req aborts any conversion in flight. No conv_start occurs while it is high, and both queues are idle once it drops.
- R10: With frz_en=1 and frz_in=1, the current conversion completes without an abort and no new conversion starts. On release, the next entry runs. frz_in has no effect when frz_en=0.
- R11: In repeat mode (mode input 1), completing the last entry sets the done flag and the first entry runs again with no new trigger.
- R12: conv_abort lasts one cycle and only appears while a conversion is in flight. conv_start never appears while a conversion is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| q1_trig | input | 1 | Urgent-queue trigger pulse |
| q2_trig | input | 1 | Background-queue trigger pulse |
| q1_en | input | 1 | Urgent-queue enable |
| q2_en | input | 1 | Background-queue enable |
| q1_mode | input | 1 | Urgent-queue mode: 0 once per trigger, 1 repeat |
| q2_mode | input | 1 | Background-queue mode: 0 once per trigger, 1 repeat |
| q1_first | input | IDX_W | Urgent-queue first entry |
| q1_last | input | IDX_W | Urgent-queue last entry |
| q2_first | input | IDX_W | Background-queue first entry |
| q2_last | input | IDX_W | Background-queue last entry |
| resume_at_abort | input | 1 | Background resume point: 0 sub-block start, 1 aborted entry |
| stop_req | input | 1 | Low-power stop request |
| frz_en | input | 1 | Freeze enable |
| frz_in | input | 1 | Freeze request |
| q1_ie | input | 1 | Urgent-queue interrupt enable |
| q2_ie | input | 1 | Background-queue interrupt enable |
| clr_done | input | 2 | Write-one-to-clear pulses for the done flags |
| ccw_sub_end | input | 1 | Sub-block end flag of the entry at ccw_idx |
| conv_done | input | 1 | Converter finished the current conversion |
| ccw_idx | output | IDX_W | Entry being converted |
| conv_start | output | 1 | One-cycle start strobe |
| conv_abort | output | 1 | One-cycle abort strobe |
| q1_done | output | 1 | Urgent-queue done flag |
| q2_done | output | 1 | Background-queue done flag |
| q1_irq | output | 1 | Urgent-queue interrupt request |
| q2_irq | output | 1 | Background-queue interrupt request |

## Verification
A converter model in the bench answers each start after a fixed latency and records every started index. Whole index sequences are then compared against the expected ones. A single uninterrupted scan checks ordering and the done/interrupt logic. Preempting the background queue at entry 13, after a sub-block mark at entry 11, is run once with each resume setting: a restart at 12 separates the sub-block policy from a restart at 13 and from a restart at the queue's first entry. Disable, mode change and stop are each applied mid-conversion to show that they abort and leave the queue idle. Freeze is applied mid-conversion to show the opposite: the conversion finishes, nothing is aborted, and the run goes on at the next entry.

// File: rtl/qseq_pkg.sv
package qseq_pkg;
  localparam int NQ   = 2;   // queue count; index 0 has top priority
  localparam int Q_HI = 0;
  localparam int Q_LO = 1;

  typedef enum logic {
    MODE_ONCE   = 1'b0,
    MODE_REPEAT = 1'b1
  } qmode_e;
endpackage

// File: rtl/qseq_queue.sv
module qseq_queue
  import qseq_pkg::*;
#(
  parameter int NUM_CCW = 40,
  parameter int IDX_W   = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig,
  input  logic             en,
  input  logic             mode,
  input  logic [IDX_W-1:0] first_idx,
  input  logic [IDX_W-1:0] last_idx,
  input  logic             resume_at_abort,
  input  logic             kill,        // stop request
  input  logic             clr,
  input  logic             fin,         // owned conversion completed
  input  logic             sub_end,     // flag of the completing entry
  input  logic             preempted,   // owned conversion cut by higher queue
  output logic             active,
  output logic             accept,
  output logic             cancel,
  output logic [IDX_W-1:0] ptr,
  output logic             done_flag
);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NUM_CCW - 1);

  logic             mode_q;
  logic [IDX_W-1:0] sub_start;
  logic [IDX_W-1:0] ptr_next;
  logic             at_last;

  assign ptr_next = (ptr == TOP_IDX) ? '0 : ptr + 1'b1;
  assign at_last  = (ptr == last_idx);
  assign cancel   = active & (~en | (mode != mode_q));
  assign accept   = trig & en & ~active & ~kill & (mode == mode_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= MODE_ONCE;
      active    <= 1'b0;
      ptr       <= '0;
      sub_start <= '0;
      done_flag <= 1'b0;
    end else begin
      mode_q <= mode;
      if (fin && at_last)
        done_flag <= 1'b1;
      else if (clr)
        done_flag <= 1'b0;

      if (cancel || kill) begin
        active <= 1'b0;
      end else if (accept) begin
        active    <= 1'b1;
        ptr       <= first_idx;
        sub_start <= first_idx;
      end else if (fin) begin
        if (at_last) begin
          ptr       <= first_idx;
          sub_start <= first_idx;
          if (mode_q == MODE_ONCE)
            active <= 1'b0;
        end else begin
          ptr <= ptr_next;
          if (sub_end)
            sub_start <= ptr_next;
        end
      end else if (preempted && !resume_at_abort) begin
        ptr <= sub_start;
      end
    end
  end
endmodule

// File: rtl/qseq_arb.sv
module qseq_arb
  import qseq_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NQ-1:0]             q_active,
  input  logic [NQ-1:0]             q_accept,
  input  logic [NQ-1:0]             q_cancel,
  input  logic [NQ-1:0][IDX_W-1:0]  q_ptr,
  input  logic                      stop,
  input  logic                      frozen,
  input  logic                      conv_done,
  output logic [NQ-1:0]             q_fin,
  output logic [NQ-1:0]             q_preempt,
  output logic [IDX_W-1:0]          ccw_idx,
  output logic                      conv_start,
  output logic                      conv_abort
);
  localparam int OW = $clog2(NQ);

  logic          busy;
  logic [OW-1:0] owner;
  logic [OW-1:0] sel;
  logic          found;
  logic          hi_req;
  logic          abort_now;
  logic          start_ok;

  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int i = NQ - 1; i >= 0; i--) begin
      if (q_active[i] && !q_cancel[i]) begin
        found = 1'b1;
        sel   = OW'(i);
      end
    end
  end

  always_comb begin
    hi_req = 1'b0;
    for (int i = 0; i < NQ; i++)
      if ((OW'(i) < owner) && q_accept[i])
        hi_req = 1'b1;
  end

  assign abort_now = busy & ~conv_done & (q_cancel[owner] | stop | hi_req);
  assign start_ok  = ~busy & ~stop & ~frozen & ~(|q_accept) & found;

  generate
    for (genvar g = 0; g < NQ; g++) begin : g_q
      assign q_fin[g]     = busy & conv_done & (owner == OW'(g));
      assign q_preempt[g] = abort_now & hi_req & ~stop & ~q_cancel[owner]
                            & (owner == OW'(g));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      owner      <= '0;
      ccw_idx    <= '0;
      conv_start <= 1'b0;
      conv_abort <= 1'b0;
    end else begin
      conv_start <= 1'b0;
      conv_abort <= abort_now;
      if (abort_now) begin
        busy <= 1'b0;
      end else if (busy && conv_done) begin
        busy <= 1'b0;
      end else if (start_ok) begin
        busy       <= 1'b1;
        owner      <= sel;
        ccw_idx    <= q_ptr[sel];
        conv_start <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/qseq_top.sv
module qseq_top
  import qseq_pkg::*;
#(
  parameter int NUM_CCW = 40,
  parameter int IDX_W   = $clog2(NUM_CCW)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             q1_trig,
  input  logic             q2_trig,
  input  logic             q1_en,
  input  logic             q2_en,
  input  logic             q1_mode,
  input  logic             q2_mode,
  input  logic [IDX_W-1:0] q1_first,
  input  logic [IDX_W-1:0] q1_last,
  input  logic [IDX_W-1:0] q2_first,
  input  logic [IDX_W-1:0] q2_last,
  input  logic             resume_at_abort,
  input  logic             stop_req,
  input  logic             frz_en,
  input  logic             frz_in,
  input  logic             q1_ie,
  input  logic             q2_ie,
  input  logic [1:0]       clr_done,
  input  logic             ccw_sub_end,
  input  logic             conv_done,
  output logic [IDX_W-1:0] ccw_idx,
  output logic             conv_start,
  output logic             conv_abort,
  output logic             q1_done,
  output logic             q2_done,
  output logic             q1_irq,
  output logic             q2_irq
);
  logic [NQ-1:0]            trig_v, en_v, mode_v, ie_v;
  logic [NQ-1:0][IDX_W-1:0] first_v, last_v, ptr_v;
  logic [NQ-1:0]            active_v, accept_v, cancel_v, fin_v, pre_v, done_v;

  assign trig_v  = {q2_trig, q1_trig};
  assign en_v    = {q2_en, q1_en};
  assign mode_v  = {q2_mode, q1_mode};
  assign ie_v    = {q2_ie, q1_ie};
  assign first_v = {q2_first, q1_first};
  assign last_v  = {q2_last, q1_last};

  generate
    for (genvar g = 0; g < NQ; g++) begin : g_queue
      qseq_queue #(.NUM_CCW(NUM_CCW), .IDX_W(IDX_W)) u_queue (
        .clk(clk), .rst(rst),
        .trig(trig_v[g]), .en(en_v[g]), .mode(mode_v[g]),
        .first_idx(first_v[g]), .last_idx(last_v[g]),
        .resume_at_abort(resume_at_abort), .kill(stop_req),
        .clr(clr_done[g]), .fin(fin_v[g]), .sub_end(ccw_sub_end),
        .preempted(pre_v[g]),
        .active(active_v[g]), .accept(accept_v[g]), .cancel(cancel_v[g]),
        .ptr(ptr_v[g]), .done_flag(done_v[g])
      );
    end
  endgenerate

  qseq_arb #(.IDX_W(IDX_W)) u_arb (
    .clk(clk), .rst(rst),
    .q_active(active_v), .q_accept(accept_v), .q_cancel(cancel_v),
    .q_ptr(ptr_v), .stop(stop_req), .frozen(frz_en & frz_in),
    .conv_done(conv_done), .q_fin(fin_v), .q_preempt(pre_v),
    .ccw_idx(ccw_idx), .conv_start(conv_start), .conv_abort(conv_abort)
  );

  assign q1_done = done_v[Q_HI];
  assign q2_done = done_v[Q_LO];
  assign q1_irq  = done_v[Q_HI] & ie_v[Q_HI];
  assign q2_irq  = done_v[Q_LO] & ie_v[Q_LO];
endmodule

// File: rtl/qseq_sva.sv
module qseq_sva (
  input logic clk,
  input logic rst,
  input logic conv_start,
  input logic conv_abort,
  input logic conv_done,
  input logic stop_req,
  input logic frz_en,
  input logic frz_in,
  input logic q1_done,
  input logic q2_done
);
  logic in_flight;

  always_ff @(posedge clk) begin
    if (rst)
      in_flight <= 1'b0;
    else if (conv_start)
      in_flight <= 1'b1;
    else if (conv_done || conv_abort)
      in_flight <= 1'b0;
  end

  p_abort_one_cycle_r12: assert property (@(posedge clk) disable iff (rst)
    conv_abort |=> !conv_abort);

  p_abort_in_flight_r12: assert property (@(posedge clk) disable iff (rst)
    conv_abort |-> in_flight);

  p_start_when_idle_r12: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> !in_flight);

  p_stop_blocks_start_r9: assert property (@(posedge clk) disable iff (rst)
    stop_req |=> !conv_start);

  p_freeze_blocks_start_r10: assert property (@(posedge clk) disable iff (rst)
    (frz_en && frz_in) |=> !conv_start);

  p_q1_done_on_finish_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(q1_done) |-> $past(conv_done));

  p_q2_done_on_finish_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(q2_done) |-> $past(conv_done));
endmodule

bind qseq_top qseq_sva u_sva (
  .clk(clk), .rst(rst), .conv_start(conv_start), .conv_abort(conv_abort),
  .conv_done(conv_done), .stop_req(stop_req), .frz_en(frz_en),
  .frz_in(frz_in), .q1_done(q1_done), .q2_done(q2_done)
);

// File: tb/qseq_top_tb.sv
module qseq_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W      = 6;
  localparam int LAT        = 4;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic q1_trig = 0, q2_trig = 0, q1_en = 1, q2_en = 1, q1_mode = 0, q2_mode = 0;
  logic [IDX_W-1:0] q1_first = 0, q1_last = 1, q2_first = 10, q2_last = 15;
  logic resume_at_abort = 0, stop_req = 0, frz_en = 0, frz_in = 0;
  logic q1_ie = 1, q2_ie = 1;
  logic [1:0] clr_done = 0;
  logic ccw_sub_end;
  logic conv_done = 0;
  logic [IDX_W-1:0] ccw_idx;
  logic conv_start, conv_abort, q1_done, q2_done, q1_irq, q2_irq;

  int total = 0, bad = 0, cyc = 0;
  int log_idx [64];
  int n_start = 0, n_abort = 0, n_overlap = 0, cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qseq_top dut_i (
    .clk(clk), .rst(rst), .q1_trig(q1_trig), .q2_trig(q2_trig),
    .q1_en(q1_en), .q2_en(q2_en), .q1_mode(q1_mode), .q2_mode(q2_mode),
    .q1_first(q1_first), .q1_last(q1_last), .q2_first(q2_first), .q2_last(q2_last),
    .resume_at_abort(resume_at_abort), .stop_req(stop_req), .frz_en(frz_en),
    .frz_in(frz_in), .q1_ie(q1_ie), .q2_ie(q2_ie), .clr_done(clr_done),
    .ccw_sub_end(ccw_sub_end), .conv_done(conv_done), .ccw_idx(ccw_idx),
    .conv_start(conv_start), .conv_abort(conv_abort), .q1_done(q1_done),
    .q2_done(q2_done), .q1_irq(q1_irq), .q2_irq(q2_irq)
  );

  // entry 11 closes a sub-block
  assign ccw_sub_end = (ccw_idx == 6'd11);

  // converter model and start/abort recorder
  always @(negedge clk) begin
    conv_done <= 1'b0;
    if (rst) begin
      cnt = 0;
    end else begin
      if (conv_start && conv_abort) n_overlap++;
      if (conv_abort) n_abort++;
      if (conv_start) begin
        if (n_start < 64) log_idx[n_start] = int'(ccw_idx);
        n_start++;
      end
      if (conv_abort) cnt = 0;
      else if (conv_start) cnt = LAT;
      else if (cnt != 0) begin
        cnt--;
        if (cnt == 0) conv_done <= 1'b1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  task automatic clr_log();
    n_start = 0;
    n_abort = 0;
  endtask

  task automatic chk_seq(input string req, input int len, input int e [12]);
    chk(n_start == len, {req, " start count"}, n_start, len);
    for (int i = 0; i < len && i < n_start; i++)
      chk(log_idx[i] == e[i], {req, " started index"}, log_idx[i], e[i]);
  endtask

  task automatic wait_start(input int idx);
    do @(negedge clk); while (!(conv_start && int'(ccw_idx) == idx));
  endtask

  task automatic pulse_clr(input int q);
    clr_done[q] = 1'b1;
    @(negedge clk);
    clr_done = '0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    cycles(3);
    chk(!conv_start && !conv_abort && ccw_idx == 0, "R1 strobes/index in reset", 0, 0);
    chk(!q1_done && !q2_done && !q1_irq && !q2_irq, "R1 flags in reset", 0, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!conv_start && !conv_abort && !q1_done && !q2_done, "R1 after release", 0, 0);
  endtask

  task automatic t_single_scan();
    int e [12] = '{2, 3, 4, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    q1_first = 2; q1_last = 4;
    clr_log();
    q1_trig = 1; @(negedge clk); q1_trig = 0;
    cycles(5);
    q1_trig = 1; @(negedge clk); q1_trig = 0;   // ignored, R2
    cycles(40);
    chk_seq("R2 single scan order", 3, e);
    chk(n_abort == 0, "R2 no abort", n_abort, 0);
    chk(q1_done && q1_irq, "R3 done and irq set", {q1_done, q1_irq}, 3);
    cycles(5);
    chk(q1_done, "R3 done sticky", q1_done, 1);
    pulse_clr(0);
    chk(!q1_done && !q1_irq, "R3 clear pulse", q1_done, 0);
  endtask

  task automatic t_irq_mask();
    q2_first = 20; q2_last = 21; q2_ie = 0;
    clr_log();
    q2_trig = 1; @(negedge clk); q2_trig = 0;
    cycles(30);
    chk(q2_done && !q2_irq, "R3 masked irq", q2_irq, 0);
    q2_ie = 1;
    @(negedge clk);
    chk(q2_irq, "R3 irq follows enable", q2_irq, 1);
    pulse_clr(1);
    chk(!q2_done, "R3 q2 clear", q2_done, 0);
    q2_first = 10; q2_last = 15;
  endtask

  task automatic t_preempt(input bit res);
    int e0 [12] = '{10, 11, 12, 13, 0, 1, 12, 13, 14, 15, 0, 0};
    int e1 [12] = '{10, 11, 12, 13, 0, 1, 13, 14, 15, 0, 0, 0};
    resume_at_abort = res;
    q1_first = 0; q1_last = 1;
    clr_log();
    q2_trig = 1; @(negedge clk); q2_trig = 0;
    wait_start(13);
    q1_trig = 1; @(negedge clk); q1_trig = 0;
    cycles(90);
    chk(n_abort == 1, "R4 one abort on preemption", n_abort, 1);
    if (res) chk_seq("R6 resume at aborted entry", 9, e1);
    else     chk_seq("R5 resume at sub-block start", 10, e0);
    chk(q1_done && q2_done, "R4 both queues finish", {q1_done, q2_done}, 3);
    pulse_clr(0); pulse_clr(1);
    resume_at_abort = 0;
  endtask

  task automatic t_disable();
    clr_log();
    q2_trig = 1; @(negedge clk); q2_trig = 0;
    wait_start(11);
    q2_en = 0;
    cycles(40);
    chk(n_abort == 1, "R7 disable aborts", n_abort, 1);
    chk(n_start == 2, "R7 no starts after disable", n_start, 2);
    chk(!q2_done, "R7 no done", q2_done, 0);
    q2_en = 1;
    @(negedge clk);
  endtask

  task automatic t_mode_and_repeat();
    clr_log();
    q2_trig = 1; @(negedge clk); q2_trig = 0;
    wait_start(11);
    q2_mode = 1;
    cycles(30);
    chk(n_abort == 1, "R8 mode change aborts", n_abort, 1);
    chk(n_start == 2, "R8 idle after mode change", n_start, 2);
    q2_trig = 1; @(negedge clk); q2_trig = 0;
    cycles(70);
    chk(n_start >= 9 && log_idx[2] == 10, "R8 restart at first entry", log_idx[2], 10);
    chk(n_start >= 9 && log_idx[8] == 10, "R11 repeat wraps", log_idx[8], 10);
    chk(q2_done, "R11 done in repeat", q2_done, 1);
    q2_en = 0;
    cycles(3);
    q2_mode = 0;
    q2_en = 1;
    cycles(2);
    pulse_clr(1);
  endtask

  task automatic t_stop();
    q1_first = 0; q1_last = 3;
    clr_log();
    q1_trig = 1; @(negedge clk); q1_trig = 0;
    wait_start(1);
    stop_req = 1;
    cycles(12);
    chk(n_abort == 1 && n_start == 2, "R9 stop aborts and holds", n_start, 2);
    stop_req = 0;
    cycles(30);
    chk(n_start == 2, "R9 idle after stop", n_start, 2);
    q1_trig = 1; @(negedge clk); q1_trig = 0;
    cycles(40);
    chk(log_idx[2] == 0, "R9 restart on trigger", log_idx[2], 0);
    pulse_clr(0);
  endtask

  task automatic t_freeze();
    int e [12] = '{0, 1, 2, 3, 0, 0, 0, 0, 0, 0, 0, 0};
    q1_first = 0; q1_last = 3;
    frz_en = 1;
    clr_log();
    q1_trig = 1; @(negedge clk); q1_trig = 0;
    wait_start(1);
    frz_in = 1;
    cycles(30);
    chk(n_abort == 0, "R10 freeze does not abort", n_abort, 0);
    chk(n_start == 2, "R10 no start while frozen", n_start, 2);
    frz_in = 0;
    cycles(40);
    chk_seq("R10 continues at next entry", 4, e);
    frz_en = 0; frz_in = 1;
    clr_log();
    q1_trig = 1; @(negedge clk); q1_trig = 0;
    cycles(40);
    chk(n_start == 4, "R10 freeze ignored when disabled", n_start, 4);
    frz_in = 0;
    pulse_clr(0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      bad++;
      total++;
      $display("FAIL watchdog: got %0d expected %0d cycles", cyc, WATCHDOG);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_single_scan();
    t_irq_mask();
    t_preempt(1'b0);
    t_preempt(1'b1);
    t_disable();
    t_mode_and_repeat();
    t_stop();
    t_freeze();
    chk(n_overlap == 0, "R12 start and abort never together", n_overlap, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule